// File: doc/BRIEF.md
# Mailbox Message Queue with Packed Status

This block is a word-wide first-in first-out queue that carries mail words from one processor to another. A producer appends words through a push port. A consumer removes the oldest word through a pop port and can inspect that word through a peek port without removing it. A 32-bit status word reports the full flag, the empty flag and the fill level.

Removal always takes the head entry, and every remaining entry moves one slot toward the head. Slots that do not hold a live word always contain a fixed invalid-data marker, `32'hFFFF_FFFF`. A pop on an empty queue returns that marker, so a consumer never sees stale data. Bus decoding, interrupt generation and channel routing belong to the surrounding controller.

Push and pop requests are sampled on a rising clock edge. All results are registered and appear after that edge: the popped word, the peek word, the status word and the error pulses.

Top module: `mbox_queue`

## Requirements
- R1: After synchronous reset, the status reads `32'h4000_0000` (empty set, full clear, level 0). Both `peek_data` and `pop_data` read the marker `32'hFFFF_FFFF`, and `overflow` and `underflow` are low.
- R2: `status` bit 31 is 1 exactly when the fill level equals DEPTH. Bit 30 is 1 exactly when the level is 0. Bits 7:0 hold the level, and bits 29:8 are zero. The word reflects the state after the most recent edge.
- R3: Accepted pushes are stored in arrival order. The first word pushed into an empty queue becomes the head.
- R4: A pop on a non-empty queue puts the head word on `pop_data` after the edge. The next-oldest word then becomes the head, and the level drops by one.
- R5: A pop on an empty queue puts the marker on `pop_data` and leaves the contents and level unchanged. It raises `underflow` for exactly one cycle.
- R6: A push on a full queue with no pop in the same cycle is ignored: contents and level stay unchanged. It raises `overflow` for exactly one cycle.
- R7: `peek_data` shows the head word without removing it. Cycles with no accepted request leave it unchanged.
- R8: A push and a pop in the same cycle on a non-empty queue (including a full one) are both honoured. The level stays the same and no pulse is raised.
- R9: A push and a pop in the same cycle on an empty queue accept the push (level becomes 1). The pop returns the marker and raises `underflow`.
- R10: A slot vacated by a pop holds the marker, so draining the queue leaves `peek_data` equal to `32'hFFFF_FFFF`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Append `push_data` this cycle |
| push_data | input | DW | Word to append |
| pop_req | input | 1 | Remove the head this cycle |
| pop_data | output | DW | Word returned by the most recent pop (marker on underflow); held between pops |
| peek_data | output | DW | Current head word, marker when empty |
| status | output | 32 | {full, empty, 22'b0, level[7:0]} |
| overflow | output | 1 | One-cycle pulse: push refused because the queue was full |
| underflow | output | 1 | One-cycle pulse: pop on an empty queue |

## Verification
Every result of a request sampled at edge N becomes visible after edge N: `pop_data`, `peek_data`, `status`, `overflow` and `underflow` all change in the cycle that follows. Only one register stage lies between the request and the outputs. The bench drives each request just after an edge, waits for the next edge, and samples 1 ns later. It compares every output against a queue model that it updates with the same request at that same point. The pulses are checked low again on the following idle cycle, so a pulse that stays high longer than one cycle is caught.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STAT_FULL_BIT  = 31;
  localparam int STAT_EMPTY_BIT = 30;
  localparam int STAT_W         = 32;

  function automatic logic [63:0] marker64();
    return 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic          pop_req,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_n,
  output logic [CW-1:0] widx,
  output logic          do_push,
  output logic          do_pop,
  output logic          pop_empty,
  output logic          ovf_q,
  output logic          unf_q
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic is_empty, is_full;

  always_comb begin
    is_empty  = (cnt_q == '0);
    is_full   = (cnt_q == FULL_CNT);
    do_pop    = pop_req && !is_empty;
    pop_empty = pop_req && is_empty;
    do_push   = push_valid && (!is_full || do_pop);
    widx      = do_pop ? cnt_q - CW'(1) : cnt_q;
    cnt_n     = cnt_q;
    if (do_push && !do_pop) cnt_n = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ovf_q <= push_valid && !do_push;
      unf_q <= pop_empty;
    end
  end

  a_r6_overflow_at_full: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt_q == FULL_CNT));

  a_r5_underflow_from_empty: assert property (@(posedge clk) disable iff (rst)
    unf_q |-> ($past(cnt_q) == '0));

  a_r8_level_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_push,
  input  logic          do_pop,
  input  logic [CW-1:0] widx,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] cnt,
  output logic [DW-1:0] head
);
  localparam logic [DW-1:0] MARK = DW'(mbx_pkg::marker64());

  logic [DW-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] shifted;
    if (i == DEPTH - 1) begin : g_tail
      assign shifted = MARK;
    end else begin : g_mid
      assign shifted = slot[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slot[i] <= MARK;
      end else if (do_push && widx == CW'(i)) begin
        slot[i] <= din;
      end else if (do_pop) begin
        slot[i] <= shifted;
      end
    end
  end

  assign head = slot[0];

  a_r10_empty_holds_marker: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> (slot[0] == MARK));

  a_r7_head_hold: assert property (@(posedge clk) disable iff (rst)
    (!do_pop && !(do_push && widx == '0)) |=> $stable(slot[0]));
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int LVLW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_n,
  output logic [31:0]   status
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [31:0] word_n;

  always_comb begin
    word_n = '0;
    word_n[mbx_pkg::STAT_FULL_BIT]  = (cnt_n == FULL_CNT);
    word_n[mbx_pkg::STAT_EMPTY_BIT] = (cnt_n == '0);
    word_n[LVLW-1:0]                = LVLW'(cnt_n);
  end

  always_ff @(posedge clk) begin
    if (rst) status <= 32'h4000_0000;
    else     status <= word_n;
  end

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(status[mbx_pkg::STAT_FULL_BIT] && status[mbx_pkg::STAT_EMPTY_BIT]));
endmodule

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int LVLW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic [DW-1:0] peek_data,
  output logic [31:0]   status,
  output logic          overflow,
  output logic          underflow
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [DW-1:0] MARK = DW'(mbx_pkg::marker64());

  logic [CW-1:0] cnt_q, cnt_n, widx;
  logic do_push, do_pop, pop_empty;
  logic [DW-1:0] head;

  mbx_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .push_valid(push_valid), .pop_req(pop_req),
    .cnt_q(cnt_q), .cnt_n(cnt_n), .widx(widx), .do_push(do_push),
    .do_pop(do_pop), .pop_empty(pop_empty), .ovf_q(overflow), .unf_q(underflow)
  );

  mbx_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .do_push(do_push), .do_pop(do_pop), .widx(widx),
    .din(push_data), .cnt(cnt_q), .head(head)
  );

  mbx_status #(.DEPTH(DEPTH), .CW(CW), .LVLW(LVLW)) u_status (
    .clk(clk), .rst(rst), .cnt_n(cnt_n), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst)            pop_data <= MARK;
    else if (do_pop)    pop_data <= head;
    else if (pop_empty) pop_data <= MARK;
  end

  assign peek_data = head;

  a_r4_pop_lowers_level: assert property (@(posedge clk) disable iff (rst)
    (do_pop && !do_push) |=> (status[LVLW-1:0] == LVLW'($past(cnt_q) - CW'(1))));
endmodule

// File: tb/sim_mbox_queue.sv
`timescale 1ns/1ps
module sim_mbox_queue;
  localparam int D = 4;
  localparam logic [31:0] MARK = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic pop_req = 1'b0;
  logic [31:0] pop_data, peek_data, status;
  logic overflow, underflow;

  always #4 clk = ~clk;

  mbox_queue #(.DEPTH(D), .DW(32), .LVLW(8)) u0 (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .peek_data(peek_data),
    .status(status), .overflow(overflow), .underflow(underflow)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] m [D];
  int mcnt = 0;
  logic [31:0] mpop = MARK;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag, input bit eo, input bit eu);
    logic [31:0] es;
    es = {(mcnt == D), (mcnt == 0), 22'b0, 8'(mcnt)};
    chk(tag, "status", status, es);
    chk(tag, "peek", peek_data, (mcnt > 0) ? m[0] : MARK);
    chk(tag, "pop_data", pop_data, mpop);
    chk(tag, "overflow", {31'b0, overflow}, {31'b0, eo});
    chk(tag, "underflow", {31'b0, underflow}, {31'b0, eu});
  endtask

  task automatic step(input bit p, input logic [31:0] d, input bit q, input string tag);
    bit eo, eu, popped, acc;
    push_valid = p; push_data = d; pop_req = q;
    @(posedge clk); #1;
    popped = q && (mcnt > 0);
    eu = q && (mcnt == 0);
    acc = p && ((mcnt < D) || popped);
    eo = p && !acc;
    if (popped) begin
      mpop = m[0];
      for (int i = 0; i < D - 1; i++) m[i] = m[i+1];
      m[D-1] = MARK;
      mcnt--;
    end else if (eu) begin
      mpop = MARK;
    end
    if (acc) begin
      m[mcnt] = d;
      mcnt++;
    end
    compare(tag, eo, eu);
    push_valid = 1'b0; pop_req = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < D; i++) m[i] = MARK;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    compare("R1", 1'b0, 1'b0);
    // R3: fill in order
    for (int i = 0; i < D; i++) step(1'b1, 32'hA000_0000 + 32'(i), 1'b0, "R3");
    // R6: push while full, then idle to see pulse end
    step(1'b1, 32'hDEAD_0001, 1'b0, "R6");
    step(1'b0, 32'h0, 1'b0, "R6");
    // R7: peek holds head
    step(1'b0, 32'h0, 1'b0, "R7");
    // R8: push and pop while full
    step(1'b1, 32'hB000_0001, 1'b1, "R8");
    step(1'b1, 32'hB000_0002, 1'b1, "R8");
    // R4: drain
    for (int i = 0; i < D; i++) step(1'b0, 32'h0, 1'b1, "R4");
    // R10: drained queue shows marker
    step(1'b0, 32'h0, 1'b0, "R10");
    // R5: pop while empty, then idle
    step(1'b0, 32'h0, 1'b1, "R5");
    step(1'b0, 32'h0, 1'b0, "R5");
    // R9: push and pop while empty
    step(1'b1, 32'hC000_0009, 1'b1, "R9");
    step(1'b0, 32'h0, 1'b1, "R9");
    // R2: pseudo-random sweep over every request mix and level
    for (int n = 0; n < 3000; n++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      step(rng[0] | rng[1], rng, rng[2] & ~rng[3] | rng[4] & rng[5], "R2");
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule